// File: doc/BRIEF.md
# Dual-Target Two-Wire Write Slave

This block is a write-only slave on a two-wire serial bus (I2C-style SCL/SDA). It answers to two 7-bit device identifiers. One identifier selects a byte-addressed nonvolatile memory. The other selects a bank of 16-bit volatile sensor registers. Both bus lines are sampled on a fast system clock. The block finds START and STOP, checks the device byte, latches the address byte that follows, and then takes in data bytes. It pulls SDA low on the acknowledge clock of every byte it accepts.

Memory bytes go out one at a time to an external page-write engine, each with its byte address. The address advances inside the current page and wraps around within that page. When the transfer ends with STOP, the engine gets a single commit strobe. Register writes are held back until STOP, and only a complete two-byte word is committed. While the memory engine reports that a write is in progress, the block does not acknowledge either identifier, so a master can poll for readiness. Read transfers, clock stretching and pad behaviour are handled elsewhere.

Top module: `dual_wr_slave`

## Requirements
- R1: After reset, and whenever no acknowledge is due, `sdaOe` is 0. START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Both lines pass through a two-flop synchronizer before they are used.
- R2: After a START, a device byte whose upper seven bits equal `MEM_ID` or `REG_ID` and whose bit 0 is 0 is acknowledged. Any other device byte, including one with bit 0 set, is not acknowledged. In that case later bytes are neither acknowledged nor acted on until the next START or STOP.
- R3: While `memBusy` is 1 at the acknowledge point of the device byte, neither identifier is acknowledged. Once `memBusy` is 0, the same device byte is acknowledged again.
- R4: In a memory transfer, the address byte and every data byte are acknowledged. Each data byte produces exactly one single-cycle `memWrValid` pulse, carrying the byte in `memWrData` and its address in `memWrAddr`. The first data byte goes to the address byte itself.
- R5: After each memory data byte, the low `PAGE_BITS` bits of the address go up by one and wrap to 0. The upper bits stay fixed, so with 4 page bits and a start at 0x3E the bytes land at 0x3E, 0x3F and 0x30.
- R6: On STOP, `memCommit` pulses for one cycle if at least one complete memory data byte was accepted since the last START. Otherwise it stays 0.
- R7: In a register transfer, the first data byte is the most significant byte and the second is the least significant byte, and both are acknowledged. `regWrValid` stays 0 until STOP. On STOP it pulses once, with `regWrData` = {first, second} and `regWrIdx` = the low `REG_IDX_BITS` bits of the address byte.
- R8: A register transfer that reaches STOP with fewer than two complete data bytes commits nothing. A third or later data byte is not acknowledged and leaves the committed word as the first two bytes.
- R9: A START or STOP that arrives in the middle of a byte throws away the partial byte. A START makes the next byte be matched as a device byte again, and a register word that is not yet committed is dropped.
- R10: `sdaOe` changes only after an SCL falling edge. It is 1 from the falling edge after the eighth bit of an accepted byte until the next falling edge, and it never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| memBusy | input | 1 | Memory engine is running an internal write |
| sdaOe | output | 1 | 1 pulls SDA low (acknowledge) |
| memWrValid | output | 1 | One memory data byte is available |
| memWrAddr | output | 8 | Byte address for `memWrData` |
| memWrData | output | 8 | Memory data byte |
| memCommit | output | 1 | STOP ended a memory transfer that carried data |
| regWrValid | output | 1 | Commit strobe for one register word |
| regWrIdx | output | REG_IDX_BITS | Index of the register being written |
| regWrData | output | 16 | Register word, most significant byte first on the bus |

## Verification
The main write path is driven with a single memory byte, a burst that crosses the end of a page, and complete register words. These cases separate per-byte memory strobes from the single deferred register commit, and show whether the pointer wraps inside the page rather than carrying into the page bits. Device bytes with a wrong identifier, with the read direction, or sent while busy check that acknowledge is refused and that nothing is written. Short register words, extra register bytes, and START or STOP cut into a byte check the discard rules. The acknowledge drive is also sampled on every data bit, which shows whether SDA is pulled only in the ninth clock.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEv_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic loadMsb;
    logic loadLsb;
    logic memPush;
    logic regPush;
    logic memCommit;
    logic ackOn;
    logic ackOff;
  } ctrlStrb_t;

  typedef enum logic [2:0] {ST_IDLE, ST_SLAVE, ST_SUB, ST_DATA, ST_SKIP} state_t;
  typedef enum logic {TGT_MEM, TGT_REG} target_t;
endpackage

// File: rtl/dws_datapath.sv
`timescale 1ns/1ps
module dws_datapath
  import dws_pkg::*;
#(
  parameter int PAGE_BITS    = 4,
  parameter int REG_IDX_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  ctrlStrb_t               strb,
  output busEv_t                  ev,
  output logic [7:0]              rxByte,
  output logic                    sdaOe,
  output logic                    memWrValid,
  output logic [7:0]              memWrAddr,
  output logic [7:0]              memWrData,
  output logic                    memCommit,
  output logic                    regWrValid,
  output logic [REG_IDX_BITS-1:0] regWrIdx,
  output logic [15:0]             regWrData
);
  localparam int SYNC_LEN = 3;

  logic [SYNC_LEN-1:0] sclSync, sdaSync;
  logic [7:0] ptr, ptrNext, msbHold, lsbHold;

  // two synchronizing flops plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_LEN-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_LEN-2:0], sdaIn};
    end
  end

  always_comb begin
    ev.sclRise = sclSync[1] & ~sclSync[2];
    ev.sclFall = ~sclSync[1] & sclSync[2];
    ev.start   = sclSync[1] & sclSync[2] & ~sdaSync[1] & sdaSync[2];
    ev.stop    = sclSync[1] & sclSync[2] & sdaSync[1] & ~sdaSync[2];
  end

  generate
    if (PAGE_BITS >= 8) begin : g_flatWrap
      assign ptrNext = ptr + 8'd1;
    end else begin : g_pageWrap
      logic [PAGE_BITS-1:0] lowNext;
      assign lowNext = ptr[PAGE_BITS-1:0] + 1'b1;
      assign ptrNext = {ptr[7:PAGE_BITS], lowNext};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte     <= '0;
      ptr        <= '0;
      msbHold    <= '0;
      lsbHold    <= '0;
      sdaOe      <= 1'b0;
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
      memCommit  <= 1'b0;
      regWrValid <= 1'b0;
      regWrIdx   <= '0;
      regWrData  <= '0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaSync[1]};
      if (strb.loadPtr) ptr <= rxByte;
      else if (strb.incPtr) ptr <= ptrNext;
      if (strb.loadMsb) msbHold <= rxByte;
      if (strb.loadLsb) lsbHold <= rxByte;
      if (strb.ackOn) sdaOe <= 1'b1;
      else if (strb.ackOff) sdaOe <= 1'b0;
      memWrValid <= strb.memPush;
      if (strb.memPush) begin
        memWrAddr <= ptr;
        memWrData <= rxByte;
      end
      memCommit  <= strb.memCommit;
      regWrValid <= strb.regPush;
      if (strb.regPush) begin
        regWrIdx  <= ptr[REG_IDX_BITS-1:0];
        regWrData <= {msbHold, lsbHold};
      end
    end
  end
endmodule

// File: rtl/dws_control.sv
`timescale 1ns/1ps
module dws_control
  import dws_pkg::*;
#(
  parameter logic [6:0] MEM_ID = 7'h50,
  parameter logic [6:0] REG_ID = 7'h18
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     ev,
  input  logic [7:0] rxByte,
  input  logic       memBusy,
  output ctrlStrb_t  strb
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  state_t     state, stateN;
  target_t    target, targetN;
  logic [3:0] bitCnt, bitCntN;
  logic       ackPhase, ackPhaseN;
  logic [1:0] dataCnt, dataCntN;
  logic       memDirty, memDirtyN;

  always_comb begin
    strb      = '0;
    stateN    = state;
    targetN   = target;
    bitCntN   = bitCnt;
    ackPhaseN = ackPhase;
    dataCntN  = dataCnt;
    memDirtyN = memDirty;
    if (ev.start) begin
      stateN      = ST_SLAVE;
      bitCntN     = '0;
      ackPhaseN   = 1'b0;
      dataCntN    = '0;
      memDirtyN   = 1'b0;
      strb.ackOff = 1'b1;
    end else if (ev.stop) begin
      if (state == ST_DATA) begin
        strb.regPush   = (target == TGT_REG) && (dataCnt == 2'd2);
        strb.memCommit = (target == TGT_MEM) && memDirty;
      end
      stateN      = ST_IDLE;
      bitCntN     = '0;
      ackPhaseN   = 1'b0;
      dataCntN    = '0;
      memDirtyN   = 1'b0;
      strb.ackOff = 1'b1;
    end else if (state == ST_SLAVE || state == ST_SUB || state == ST_DATA) begin
      if (ev.sclRise && !ackPhase && bitCnt < BYTE_BITS) begin
        strb.shiftIn = 1'b1;
        bitCntN      = bitCnt + 4'd1;
      end else if (ev.sclFall && !ackPhase && bitCnt == BYTE_BITS) begin
        ackPhaseN = 1'b1;
        unique case (state)
          ST_SLAVE: begin
            if (!rxByte[0] && !memBusy && rxByte[7:1] == MEM_ID) begin
              strb.ackOn = 1'b1;
              targetN    = TGT_MEM;
              stateN     = ST_SUB;
            end else if (!rxByte[0] && !memBusy && rxByte[7:1] == REG_ID) begin
              strb.ackOn = 1'b1;
              targetN    = TGT_REG;
              stateN     = ST_SUB;
            end else begin
              stateN = ST_SKIP;
            end
          end
          ST_SUB: begin
            strb.ackOn   = 1'b1;
            strb.loadPtr = 1'b1;
            dataCntN     = '0;
            stateN       = ST_DATA;
          end
          default: begin
            if (target == TGT_MEM) begin
              strb.ackOn   = 1'b1;
              strb.memPush = 1'b1;
              strb.incPtr  = 1'b1;
              memDirtyN    = 1'b1;
            end else if (dataCnt == 2'd0) begin
              strb.ackOn   = 1'b1;
              strb.loadMsb = 1'b1;
              dataCntN     = 2'd1;
            end else if (dataCnt == 2'd1) begin
              strb.ackOn   = 1'b1;
              strb.loadLsb = 1'b1;
              dataCntN     = 2'd2;
            end
          end
        endcase
      end else if (ev.sclFall && ackPhase) begin
        ackPhaseN   = 1'b0;
        bitCntN     = '0;
        strb.ackOff = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      target   <= TGT_MEM;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      dataCnt  <= '0;
      memDirty <= 1'b0;
    end else begin
      state    <= stateN;
      target   <= targetN;
      bitCnt   <= bitCntN;
      ackPhase <= ackPhaseN;
      dataCnt  <= dataCntN;
      memDirty <= memDirtyN;
    end
  end
endmodule

// File: rtl/dual_wr_slave.sv
`timescale 1ns/1ps
module dual_wr_slave
  import dws_pkg::*;
#(
  parameter logic [6:0] MEM_ID       = 7'h50,
  parameter logic [6:0] REG_ID       = 7'h18,
  parameter int         PAGE_BITS    = 4,
  parameter int         REG_IDX_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic                    memBusy,
  output logic                    sdaOe,
  output logic                    memWrValid,
  output logic [7:0]              memWrAddr,
  output logic [7:0]              memWrData,
  output logic                    memCommit,
  output logic                    regWrValid,
  output logic [REG_IDX_BITS-1:0] regWrIdx,
  output logic [15:0]             regWrData
);
  busEv_t     ev;
  ctrlStrb_t  strb;
  logic [7:0] rxByte;

  dws_control #(.MEM_ID(MEM_ID), .REG_ID(REG_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .memBusy(memBusy), .strb(strb)
  );

  dws_datapath #(.PAGE_BITS(PAGE_BITS), .REG_IDX_BITS(REG_IDX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb), .ev(ev),
    .rxByte(rxByte), .sdaOe(sdaOe), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memCommit(memCommit), .regWrValid(regWrValid),
    .regWrIdx(regWrIdx), .regWrData(regWrData)
  );
endmodule

// File: rtl/dws_checker.sv
`timescale 1ns/1ps
module dws_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic memWrValid,
  input logic memCommit,
  input logic regWrValid
);
  // R10: acknowledge drive holds steady once SCL has been high long enough
  a_r10_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn, 1) && $past(sclIn, 2) && $past(sclIn, 3) && $past(sclIn, 4)
     && $past(sclIn, 5)) |-> $stable(sdaOe));

  // R4: each byte strobe lasts one cycle
  a_r4_byte_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |=> !memWrValid);

  // R6: commit strobe lasts one cycle
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memCommit |=> !memCommit);

  // R7: register commit lasts one cycle
  a_r7_reg_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |=> !regWrValid);

  // R7: a STOP commits to one target only
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |-> !memCommit);
endmodule

bind dual_wr_slave dws_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .memWrValid(memWrValid), .memCommit(memCommit), .regWrValid(regWrValid)
);

// File: tb/dual_wr_slave_bench.sv
`timescale 1ns/1ps
module dual_wr_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic memBusy = 1'b0;
  logic sdaOe, memWrValid, memCommit, regWrValid;
  logic [7:0] memWrAddr, memWrData;
  logic [2:0] regWrIdx;
  logic [15:0] regWrData;
  logic sdaLine;

  int nChecks = 0;
  int nFails = 0;
  int memCnt = 0, commitCnt = 0, regCnt = 0, oeDuringData = 0;
  logic [7:0] addrLog [16];
  logic [7:0] dataLog [16];
  logic [15:0] lastReg;
  logic [2:0] lastIdx;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  dual_wr_slave u_dual_wr_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .memBusy(memBusy),
    .sdaOe(sdaOe), .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memCommit(memCommit), .regWrValid(regWrValid), .regWrIdx(regWrIdx), .regWrData(regWrData)
  );

  always @(negedge clk) begin
    if (memWrValid) begin
      if (memCnt < 16) begin
        addrLog[memCnt] = memWrAddr;
        dataLog[memCnt] = memWrData;
      end
      memCnt++;
    end
    if (memCommit) commitCnt++;
    if (regWrValid) begin
      regCnt++;
      lastReg = regWrData;
      lastIdx = regWrIdx;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic clearLog();
    memCnt = 0; commitCnt = 0; regCnt = 0; oeDuringData = 0;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sclM = 1'b0; sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sclM = 1'b0; waitQ(1);
      sdaM = b[i]; waitQ(1);
      sclM = 1'b1; waitQ(1);
      if (sdaOe) oeDuringData++;
      waitQ(1);
    end
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    acked = (sdaLine == 1'b0);
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic t_reset();
    check(sdaOe == 1'b0, "R1 oe after reset", int'(sdaOe), 0);
    check(memCnt == 0 && regCnt == 0 && commitCnt == 0, "R1 no strobes after reset",
          memCnt + regCnt + commitCnt, 0);
  endtask

  task automatic t_memSingle();
    bit a0, a1, a2;
    clearLog();
    busStart(); writeByte(8'hA0, a0); writeByte(8'h25, a1); writeByte(8'h5A, a2); busStop();
    check(a0, "R2 memory id ack", int'(a0), 1);
    check(a1 && a2, "R4 address and data ack", int'({a1, a2}), 3);
    check(memCnt == 1, "R4 one byte strobe", memCnt, 1);
    check(addrLog[0] == 8'h25 && dataLog[0] == 8'h5A, "R4 byte addr/data",
          int'({addrLog[0], dataLog[0]}), 16'h255A);
    check(commitCnt == 1, "R6 commit on stop", commitCnt, 1);
    check(oeDuringData == 0, "R10 no drive in data bits", oeDuringData, 0);
  endtask

  task automatic t_pageWrap();
    bit a;
    clearLog();
    busStart(); writeByte(8'hA0, a); writeByte(8'h3E, a);
    writeByte(8'h11, a); writeByte(8'h22, a); writeByte(8'h33, a); busStop();
    check(memCnt == 3, "R5 three strobes", memCnt, 3);
    check(addrLog[0] == 8'h3E, "R5 first addr", int'(addrLog[0]), 8'h3E);
    check(addrLog[1] == 8'h3F, "R5 second addr", int'(addrLog[1]), 8'h3F);
    check(addrLog[2] == 8'h30, "R5 wrapped addr", int'(addrLog[2]), 8'h30);
    check(dataLog[2] == 8'h33, "R5 wrapped data", int'(dataLog[2]), 8'h33);
    check(commitCnt == 1, "R6 single commit for burst", commitCnt, 1);
  endtask

  task automatic t_badAddr();
    bit a0, a1, a2;
    clearLog();
    busStart(); writeByte(8'hA2, a0); writeByte(8'h10, a1); writeByte(8'h99, a2); busStop();
    check(!a0, "R2 foreign id nack", int'(a0), 0);
    check(!a1 && !a2, "R2 later bytes ignored", int'({a1, a2}), 0);
    check(memCnt == 0 && regCnt == 0 && commitCnt == 0, "R2 no writes after nack",
          memCnt + regCnt + commitCnt, 0);
    busStart(); writeByte(8'hA1, a0); busStop();
    check(!a0, "R2 read direction nack", int'(a0), 0);
  endtask

  task automatic t_busy();
    bit a0, a1;
    clearLog();
    memBusy = 1'b1;
    busStart(); writeByte(8'hA0, a0); busStop();
    busStart(); writeByte(8'h30, a1); busStop();
    check(!a0, "R3 memory id nack when busy", int'(a0), 0);
    check(!a1, "R3 register id nack when busy", int'(a1), 0);
    memBusy = 1'b0;
    busStart(); writeByte(8'hA0, a0); busStop();
    check(a0, "R3 ack once idle", int'(a0), 1);
    check(commitCnt == 0, "R6 no commit without data", commitCnt, 0);
  endtask

  task automatic t_regWrite();
    bit a0, a1, a2, a3;
    clearLog();
    busStart(); writeByte(8'h30, a0); writeByte(8'h05, a1);
    writeByte(8'hAB, a2); writeByte(8'hCD, a3);
    waitQ(2);
    check(regCnt == 0, "R7 no commit before stop", regCnt, 0);
    busStop();
    check(a0 && a1 && a2 && a3, "R7 all four acked", int'({a0, a1, a2, a3}), 15);
    check(regCnt == 1, "R7 one commit", regCnt, 1);
    check(lastReg == 16'hABCD, "R7 word order", int'(lastReg), 16'hABCD);
    check(lastIdx == 3'd5, "R7 register index", int'(lastIdx), 5);
    check(commitCnt == 0 && memCnt == 0, "R7 memory untouched", commitCnt + memCnt, 0);
  endtask

  task automatic t_regShort();
    bit a;
    clearLog();
    busStart(); writeByte(8'h30, a); writeByte(8'h02, a); writeByte(8'h77, a); busStop();
    check(regCnt == 0, "R8 single byte discarded", regCnt, 0);
  endtask

  task automatic t_regThird();
    bit a, a3;
    clearLog();
    busStart(); writeByte(8'h30, a); writeByte(8'h01, a);
    writeByte(8'h12, a); writeByte(8'h34, a); writeByte(8'h56, a3); busStop();
    check(!a3, "R8 third byte nack", int'(a3), 0);
    check(regCnt == 1 && lastReg == 16'h1234, "R8 word keeps first two", int'(lastReg), 16'h1234);
  endtask

  task automatic t_restart();
    bit a, aM;
    clearLog();
    busStart(); writeByte(8'h30, a); writeByte(8'h03, a); writeByte(8'h9A, a);
    sendBits(8'hF0, 4);
    busStart(); writeByte(8'hA0, aM); writeByte(8'h40, a); writeByte(8'h66, a); busStop();
    check(aM, "R9 device byte matched after restart", int'(aM), 1);
    check(regCnt == 0, "R9 pending register dropped", regCnt, 0);
    check(memCnt == 1 && addrLog[0] == 8'h40 && dataLog[0] == 8'h66, "R9 later write only",
          int'({addrLog[0], dataLog[0]}), 16'h4066);
  endtask

  task automatic t_stopMid();
    bit a;
    clearLog();
    busStart(); writeByte(8'hA0, a); writeByte(8'h10, a);
    sendBits(8'hC3, 4); busStop();
    check(memCnt == 0, "R9 partial byte dropped", memCnt, 0);
    check(commitCnt == 0, "R9 no commit for partial byte", commitCnt, 0);
    check(sdaOe == 1'b0, "R10 released after stop", int'(sdaOe), 0);
    check(oeDuringData == 0, "R10 no drive in data bits", oeDuringData, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_memSingle();
    t_pageWrap();
    t_badAddr();
    t_busy();
    t_regWrite();
    t_regShort();
    t_regThird();
    t_restart();
    t_stopMid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule